// File: doc/BRIEF.md
# Bounded Best-Path Interval Segmenter

This block receives a stream of segments. Each segment has a duration and one likelihood factor per motion mode. With every new segment it works out the most probable way to cut the recent segments into consecutive intervals, each labelled with a single mode. An interval may not last longer than a configured number of time units.

A small store of candidate start points, called nodes, keeps three things for each node:
- the duration accumulated since that node,
- the running per-mode likelihood products,
- the best path cost that ends just before the node.

The search runs over these nodes one per cycle, starting with the oldest. A node that can no longer start a legal interval is discarded. For every other node the search scores a path through it, and it then scores the interval made of only the new segment. The winning decision for each segment goes into an edge memory as a mode and the index of the first segment of its interval.

A flush request ends the run. The edge memory is then read out from the last segment backwards, jumping from the start of each interval to the segment before it. The result is the list of decided intervals, newest first. All likelihoods and costs are 16-bit unsigned fractions.

Top module: `seg_path_search`

## Requirements
- R1: After reset, `busy`, `ovf`, `bt_valid` and `bt_done` are 0. A new run starts with a previous-path cost of 0xFFFF, an empty node store and segment index 0.
- R2: Every product is the upper 16 bits of the 32-bit product of two 16-bit fractions. An interval's likelihood for mode k is 0xFFFF, multiplied in turn by the mode-k factor of each segment in the interval, oldest first. A path's cost is the cost before the interval multiplied by the interval's best mode likelihood.
- R3: An interval's mode is the one with the largest likelihood, and the lowest index wins a tie. Mode k's factor is `seg_prob[16k+15:16k]`.
- R4: An interval that spans several segments is allowed only if the sum of its durations is at most `TMAX`. An interval of one segment is always allowed.
- R5: For each new segment, the chosen interval is the allowed one with the highest path cost. On a tie, the earliest start wins.
- R6: Each segment records, at its own index, the winning mode and the index of the first segment of its interval.
- R7: A flush with at least one segment in the run produces one output per interval, starting from the last segment. Each output carries `bt_mode` and `bt_start`, and the walk continues at `bt_start`-1. `bt_done` is high together with the output whose start is 0, and in the next cycle `bt_valid` is 0. The run is then cleared. A flush on an empty run raises only `bt_done`.
- R8: `busy` is high in the cycle after a segment is accepted and stays high until that search completes.
- R9: A segment strobe that arrives while `busy` is high is held in a one-entry buffer and processed afterwards. A strobe that arrives while the buffer is full is ignored.
- R10: The node store holds `NODE_DEPTH` nodes. Pushing a node into a full store discards the oldest node and sets `ovf`, which stays at 1 until reset.
- R11: A flush that arrives while `busy` is high takes effect only after the pending search and any buffered segment have been processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_valid | input | 1 | New segment strobe |
| seg_dur | input | DW | Segment duration |
| seg_prob | input | K*16 | Per-mode likelihood factors, mode k in bits 16k+15:16k |
| flush | input | 1 | End the run and read out decisions |
| busy | output | 1 | Search or readout in progress |
| ovf | output | 1 | Sticky node store overflow |
| bt_valid | output | 1 | Readout entry valid |
| bt_mode | output | MW | Mode of the read-out interval |
| bt_start | output | SW | First segment index of that interval |
| bt_done | output | 1 | Last readout entry, or empty run |

## Verification
A wrong accumulated duration, partial product or stored path cost shows up only at readout, as a changed mode or changed interval start in the backwards walk. The bench therefore compares every readout against a reference of the search fed with the same segments, including the readout of overflowed and pruned runs. A slip in the strobe buffer or the flush ordering shows up as a missing or extra interval in that walk, and a control slip shows as `busy` failing to rise one cycle after acceptance.

// File: rtl/seg_path_pkg.sv
package seg_path_pkg;
  localparam int FXW = 16;
  localparam logic [FXW-1:0] FX_ONE = '1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_LAST,
    ST_BT_RD,
    ST_BT_OUT
  } seg_state_e;

  // unsigned all-fraction product, keep the upper half
  function automatic logic [FXW-1:0] fx_mul(input logic [FXW-1:0] a, input logic [FXW-1:0] b);
    logic [2*FXW-1:0] p;
    p = a * b;
    return p[2*FXW-1:FXW];
  endfunction
endpackage

// File: rtl/seg_lik_eval.sv
module seg_lik_eval
  import seg_path_pkg::*;
#(
  parameter int K  = 3,
  parameter int MW = 2
) (
  input  logic [K-1:0][FXW-1:0] part_i,
  input  logic [K-1:0][FXW-1:0] prob_i,
  input  logic [FXW-1:0]        path_i,
  output logic [K-1:0][FXW-1:0] upd_o,
  output logic [FXW-1:0]        cost_o,
  output logic [MW-1:0]         mode_o
);
  logic [FXW-1:0] best_l;

  for (genvar g = 0; g < K; g++) begin : g_mul
    assign upd_o[g] = fx_mul(part_i[g], prob_i[g]);
  end

  always_comb begin
    best_l = upd_o[0];
    mode_o = '0;
    for (int k = 1; k < K; k++) begin
      if (upd_o[k] > best_l) begin
        best_l = upd_o[k];
        mode_o = MW'(k);
      end
    end
    cost_o = fx_mul(path_i, best_l);
  end
endmodule

// File: rtl/seg_node_store.sv
module seg_node_store #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = IW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  push_d,
  input  logic          pop,
  input  logic          upd,
  input  logic [IW-1:0] upd_off,
  input  logic [W-1:0]  upd_d,
  input  logic [IW-1:0] rd_off,
  output logic [W-1:0]  rd_d,
  output logic [CW-1:0] cnt,
  output logic          ovf
);
  logic [W-1:0]  mem [DEPTH];
  logic [IW-1:0] head;

  assign rd_d = mem[head + rd_off];

  always_ff @(posedge clk) begin
    if (push)
      mem[head + cnt[IW-1:0]] <= push_d;
    else if (upd)
      mem[head + upd_off] <= upd_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head <= '0;
      cnt  <= '0;
      ovf  <= 1'b0;
    end else if (clr) begin
      head <= '0;
      cnt  <= '0;
    end else if (push) begin
      if (cnt == CW'(DEPTH)) begin
        head <= head + IW'(1);
        ovf  <= 1'b1;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end else if (pop && cnt != '0) begin
      head <= head + IW'(1);
      cnt  <= cnt - CW'(1);
    end
  end
endmodule

// File: rtl/seg_edge_ram.sv
module seg_edge_ram #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/seg_path_search.sv
module seg_path_search
  import seg_path_pkg::*;
#(
  parameter int K          = 3,
  parameter int DW         = 8,
  parameter int TMAX       = 20,
  parameter int NODE_DEPTH = 4,
  parameter int EDGE_DEPTH = 16,
  localparam int MW        = (K > 1) ? $clog2(K) : 1,
  localparam int SW        = $clog2(EDGE_DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           seg_valid,
  input  logic [DW-1:0]  seg_dur,
  input  logic [K*16-1:0] seg_prob,
  input  logic           flush,
  output logic           busy,
  output logic           ovf,
  output logic           bt_valid,
  output logic [MW-1:0]  bt_mode,
  output logic [SW-1:0]  bt_start,
  output logic           bt_done
);
  localparam int AW = DW + 1;
  localparam int IW = $clog2(NODE_DEPTH);
  localparam int CW = IW + 1;
  localparam int NW = AW + K*FXW + FXW + SW;
  localparam int EW = MW + SW;

  typedef struct packed {
    logic [AW-1:0]         acc;
    logic [K-1:0][FXW-1:0] part;
    logic [FXW-1:0]        path;
    logic [SW-1:0]         seg;
  } node_t;

  typedef struct packed {
    logic [MW-1:0] mode;
    logic [SW-1:0] src;
  } edge_t;

  seg_state_e            state;
  logic [DW-1:0]         cur_d, pend_d;
  logic [K-1:0][FXW-1:0] cur_p, pend_p;
  logic                  pend_v, flush_q, any_seg, have;
  logic [CW-1:0]         k_off;
  logic [FXW-1:0]        best_cost, last_best;
  logic [MW-1:0]         best_mode;
  logic [SW-1:0]         best_src, seg_n, bt_cur;

  logic [NW-1:0]         f_rd;
  node_t                 rd_n, upd_n, push_n;
  logic [CW-1:0]         node_cnt;
  logic                  f_pop, f_upd, f_push, f_clr, scan_done, too_long, take;
  logic [AW:0]           sum;
  logic [K-1:0][FXW-1:0] ev_part, ev_upd;
  logic [FXW-1:0]        ev_path, ev_cost;
  logic [MW-1:0]         ev_mode;
  logic [EW-1:0]         e_rd;
  edge_t                 er, ew;

  assign rd_n = node_t'(f_rd);
  assign er   = edge_t'(e_rd);
  assign busy = (state != ST_IDLE);

  seg_lik_eval #(.K(K), .MW(MW)) eval_i (
    .part_i(ev_part), .prob_i(cur_p), .path_i(ev_path),
    .upd_o(ev_upd), .cost_o(ev_cost), .mode_o(ev_mode)
  );

  always_comb begin
    sum       = {1'b0, rd_n.acc} + (AW+1)'(cur_d);
    too_long  = sum > (AW+1)'(TMAX);
    scan_done = (k_off == node_cnt);
    ev_part   = (state == ST_LAST) ? {K{FX_ONE}} : rd_n.part;
    ev_path   = (state == ST_LAST) ? last_best : rd_n.path;
    take      = !have || (ev_cost > best_cost);
    f_pop  = 1'b0;
    f_upd  = 1'b0;
    f_push = (state == ST_LAST);
    f_clr  = (state == ST_BT_OUT) && (er.src == '0);
    // durations only grow toward the oldest node, so an expired node is always the head
    if (state == ST_SCAN && !scan_done) begin
      if (too_long) f_pop = 1'b1;
      else          f_upd = 1'b1;
    end
    upd_n  = '{acc: sum[AW-1:0], part: ev_upd, path: rd_n.path, seg: rd_n.seg};
    push_n = '{acc: AW'(cur_d), part: ev_upd, path: last_best, seg: seg_n};
    ew     = '{mode: take ? ev_mode : best_mode, src: take ? seg_n : best_src};
  end

  seg_node_store #(.DEPTH(NODE_DEPTH), .W(NW)) nodes_i (
    .clk(clk), .rst(rst), .clr(f_clr),
    .push(f_push), .push_d(NW'(push_n)),
    .pop(f_pop), .upd(f_upd), .upd_off(k_off[IW-1:0]), .upd_d(NW'(upd_n)),
    .rd_off(k_off[IW-1:0]), .rd_d(f_rd), .cnt(node_cnt), .ovf(ovf)
  );

  seg_edge_ram #(.DEPTH(EDGE_DEPTH), .W(EW)) edges_i (
    .clk(clk), .we(state == ST_LAST), .waddr(seg_n), .wdata(EW'(ew)),
    .raddr(bt_cur), .rdata(e_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pend_v    <= 1'b0;
      flush_q   <= 1'b0;
      any_seg   <= 1'b0;
      have      <= 1'b0;
      k_off     <= '0;
      seg_n     <= '0;
      bt_cur    <= '0;
      last_best <= FX_ONE;
      best_cost <= '0;
      best_mode <= '0;
      best_src  <= '0;
      cur_d     <= '0;
      cur_p     <= '0;
      pend_d    <= '0;
      pend_p    <= '0;
      bt_valid  <= 1'b0;
      bt_done   <= 1'b0;
      bt_mode   <= '0;
      bt_start  <= '0;
    end else begin
      bt_valid <= 1'b0;
      bt_done  <= 1'b0;
      if (state != ST_IDLE && seg_valid && !pend_v) begin
        pend_v <= 1'b1;
        pend_d <= seg_dur;
        pend_p <= seg_prob;
      end
      case (state)
        ST_IDLE: begin
          if (pend_v || seg_valid) begin
            cur_d <= pend_v ? pend_d : seg_dur;
            cur_p <= pend_v ? pend_p : seg_prob;
            if (pend_v) begin
              pend_v <= seg_valid;
              pend_d <= seg_dur;
              pend_p <= seg_prob;
            end
            k_off <= '0;
            have  <= 1'b0;
            state <= ST_SCAN;
          end else if (flush_q) begin
            flush_q <= 1'b0;
            if (any_seg) begin
              bt_cur <= seg_n - SW'(1);
              state  <= ST_BT_RD;
            end else begin
              bt_done <= 1'b1;
            end
          end
        end
        ST_SCAN: begin
          if (scan_done) begin
            state <= ST_LAST;
          end else if (!too_long) begin
            k_off <= k_off + CW'(1);
            if (take) begin
              have      <= 1'b1;
              best_cost <= ev_cost;
              best_mode <= ev_mode;
              best_src  <= rd_n.seg;
            end
          end
        end
        ST_LAST: begin
          last_best <= take ? ev_cost : best_cost;
          seg_n     <= seg_n + SW'(1);
          any_seg   <= 1'b1;
          state     <= ST_IDLE;
        end
        ST_BT_RD: state <= ST_BT_OUT;
        ST_BT_OUT: begin
          bt_valid <= 1'b1;
          bt_mode  <= er.mode;
          bt_start <= er.src;
          if (er.src == '0) begin
            bt_done   <= 1'b1;
            seg_n     <= '0;
            any_seg   <= 1'b0;
            last_best <= FX_ONE;
            state     <= ST_IDLE;
          end else begin
            bt_cur <= er.src - SW'(1);
            state  <= ST_BT_RD;
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (flush) flush_q <= 1'b1;
    end
  end
endmodule

// File: rtl/seg_path_search_chk.sv
module seg_path_search_chk #(
  parameter int K          = 3,
  parameter int MW         = 2,
  parameter int CW         = 3,
  parameter int NODE_DEPTH = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          seg_valid,
  input logic          busy,
  input logic          ovf,
  input logic          bt_valid,
  input logic          bt_done,
  input logic [MW-1:0] bt_mode,
  input logic [CW-1:0] node_cnt
);
  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst) ovf |=> ovf);
  // R10
  node_cap_chk: assert property (@(posedge clk) disable iff (rst) node_cnt <= CW'(NODE_DEPTH));
  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (rst) (seg_valid && !busy) |=> busy);
  // R7
  bt_gap_chk: assert property (@(posedge clk) disable iff (rst) bt_done |=> !bt_valid);
  // R7
  bt_cont_chk: assert property (@(posedge clk) disable iff (rst) (bt_valid && !bt_done) |-> busy);
  // R3
  mode_range_chk: assert property (@(posedge clk) disable iff (rst) bt_valid |-> (int'(bt_mode) < K));
endmodule

bind seg_path_search seg_path_search_chk #(
  .K(K), .MW(MW), .CW(CW), .NODE_DEPTH(NODE_DEPTH)
) chk_i (
  .clk(clk), .rst(rst), .seg_valid(seg_valid), .busy(busy), .ovf(ovf),
  .bt_valid(bt_valid), .bt_done(bt_done), .bt_mode(bt_mode), .node_cnt(node_cnt)
);

// File: tb/seg_path_search_tb.sv
module seg_path_search_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int K = 3, DW = 8, TMAX = 20, ND = 4, ED = 16;
  localparam int MW = 2, SW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic seg_valid = 1'b0, flush = 1'b0;
  logic [DW-1:0] seg_dur = '0;
  logic [K*16-1:0] seg_prob = '0;
  logic busy, ovf, bt_valid, bt_done;
  logic [MW-1:0] bt_mode;
  logic [SW-1:0] bt_start;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_path_search #(.K(K), .DW(DW), .TMAX(TMAX), .NODE_DEPTH(ND), .EDGE_DEPTH(ED)) dut_i (
    .clk(clk), .rst(rst), .seg_valid(seg_valid), .seg_dur(seg_dur), .seg_prob(seg_prob),
    .flush(flush), .busy(busy), .ovf(ovf), .bt_valid(bt_valid), .bt_mode(bt_mode),
    .bt_start(bt_start), .bt_done(bt_done)
  );

  // reference state
  int m_acc [ND];
  logic [15:0] m_part [ND][K];
  logic [15:0] m_path [ND];
  int m_seg [ND];
  int m_cnt = 0, m_segn = 0;
  logic [15:0] m_last = 16'hFFFF;
  int e_mode [ED], e_src [ED];

  function automatic logic [15:0] fm(input logic [15:0] a, input logic [15:0] b);
    logic [31:0] p;
    p = a * b;
    return p[31:16];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic m_drop_head();
    for (int i = 0; i < ND - 1; i++) begin
      m_acc[i] = m_acc[i+1]; m_path[i] = m_path[i+1]; m_seg[i] = m_seg[i+1];
      for (int k = 0; k < K; k++) m_part[i][k] = m_part[i+1][k];
    end
    m_cnt--;
  endtask

  task automatic m_eval(input logic [15:0] part [K], input logic [15:0] path,
                        input logic [15:0] p [K], output logic [15:0] upd [K],
                        output logic [15:0] cost, output int mode);
    logic [15:0] bl;
    for (int k = 0; k < K; k++) upd[k] = fm(part[k], p[k]);
    bl = upd[0]; mode = 0;
    for (int k = 1; k < K; k++) if (upd[k] > bl) begin bl = upd[k]; mode = k; end
    cost = fm(path, bl);
  endtask

  task automatic model_seg(input int d, input logic [15:0] p [K]);
    logic [15:0] upd [K], part [K], cost, best;
    int mode, bmode, bsrc;
    bit have;
    have = 0; best = 0; bmode = 0; bsrc = 0;
    while (m_cnt > 0 && m_acc[0] + d > TMAX) m_drop_head();
    for (int i = 0; i < m_cnt; i++) begin
      for (int k = 0; k < K; k++) part[k] = m_part[i][k];
      m_eval(part, m_path[i], p, upd, cost, mode);
      if (!have || cost > best) begin have = 1; best = cost; bmode = mode; bsrc = m_seg[i]; end
      m_acc[i] += d;
      for (int k = 0; k < K; k++) m_part[i][k] = upd[k];
    end
    for (int k = 0; k < K; k++) part[k] = 16'hFFFF;
    m_eval(part, m_last, p, upd, cost, mode);
    if (!have || cost > best) begin best = cost; bmode = mode; bsrc = m_segn; end
    if (m_cnt == ND) m_drop_head();
    m_acc[m_cnt] = d; m_path[m_cnt] = m_last; m_seg[m_cnt] = m_segn;
    for (int k = 0; k < K; k++) m_part[m_cnt][k] = upd[k];
    m_cnt++;
    e_mode[m_segn] = bmode; e_src[m_segn] = bsrc;
    m_last = best; m_segn++;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
  endtask

  // one segment: drive, check busy rise, update reference, wait for the search to end
  task automatic send_seg(input int d, input logic [15:0] p0, input logic [15:0] p1, input logic [15:0] p2);
    logic [15:0] p [K];
    p[0] = p0; p[1] = p1; p[2] = p2;
    @(negedge clk);
    seg_valid = 1'b1; seg_dur = DW'(d); seg_prob = {p2, p1, p0};
    @(negedge clk);
    seg_valid = 1'b0;
    chk(busy === 1'b1, "R8 busy after strobe", int'(busy), 1);
    model_seg(d, p);
    wait_idle();
  endtask

  // flush and compare the backwards walk; returns number of entries seen
  task automatic flush_cmp(input string req, input bit do_strobe, output int seen);
    int em [ED], es [ED];
    int n, cur;
    bit done;
    n = 0;
    if (m_segn > 0) begin
      cur = m_segn - 1;
      forever begin
        em[n] = e_mode[cur]; es[n] = e_src[cur]; n++;
        if (e_src[cur] == 0) break;
        cur = e_src[cur] - 1;
      end
    end
    if (do_strobe) begin
      @(negedge clk); flush = 1'b1;
      @(negedge clk); flush = 1'b0;
    end
    seen = 0; done = 0;
    for (int t = 0; t < 400 && !done; t++) begin
      @(negedge clk);
      if (bt_valid) begin
        if (seen < n) begin
          chk(int'(bt_mode) == em[seen], {req, " mode"}, int'(bt_mode), em[seen]);
          chk(int'(bt_start) == es[seen], {req, " start"}, int'(bt_start), es[seen]);
        end
        seen++;
      end
      if (bt_done) done = 1;
    end
    chk(done, {req, " R7 done seen"}, int'(done), 1);
    chk(seen == n, {req, " R7 entry count"}, seen, n);
    m_cnt = 0; m_segn = 0; m_last = 16'hFFFF;
    wait_idle();
  endtask

  task automatic t_reset();
    chk(busy === 1'b0, "R1 busy", int'(busy), 0);
    chk(ovf === 1'b0, "R1 ovf", int'(ovf), 0);
    chk(bt_valid === 1'b0, "R1 bt_valid", int'(bt_valid), 0);
    chk(bt_done === 1'b0, "R1 bt_done", int'(bt_done), 0);
  endtask

  task automatic t_single();
    int s;
    send_seg(5, 16'h4000, 16'hC000, 16'h8000);
    chk(e_mode[0] == 1, "R3 reference mode", e_mode[0], 1);
    flush_cmp("R6 single", 1, s);
  endtask

  task automatic t_empty();
    int s;
    flush_cmp("R7 empty flush", 1, s);
  endtask

  task automatic t_chain();
    int s;
    send_seg(3, 16'hF000, 16'h1000, 16'h2000);
    send_seg(4, 16'hE800, 16'h3000, 16'h1000);
    send_seg(2, 16'hF800, 16'h2000, 16'h0800);
    send_seg(3, 16'h1000, 16'hF000, 16'h2000);
    flush_cmp("R2 R5 chain", 1, s);
  endtask

  task automatic t_prune();
    int s;
    for (int i = 0; i < 4; i++) send_seg(15, 16'hF000, 16'hF000, 16'h1000);
    flush_cmp("R4 pruned", 1, s);
    chk(s == 4, "R4 every segment alone", s, 4);
  endtask

  task automatic t_tie();
    int s;
    send_seg(2, 16'h8000, 16'h8000, 16'h1000);
    chk(e_mode[0] == 0, "R3 tie reference", e_mode[0], 0);
    flush_cmp("R3 tie lowest", 1, s);
  endtask

  task automatic t_buffer();
    logic [15:0] pa [K], pb [K];
    int s;
    pa[0] = 16'h2000; pa[1] = 16'h9000; pa[2] = 16'h1000;
    pb[0] = 16'hA000; pb[1] = 16'h1000; pb[2] = 16'h3000;
    @(negedge clk);
    seg_valid = 1'b1; seg_dur = 8'd12; seg_prob = {pa[2], pa[1], pa[0]};
    @(negedge clk);
    seg_dur = 8'd12; seg_prob = {pb[2], pb[1], pb[0]};
    @(negedge clk);
    seg_dur = 8'd1; seg_prob = {16'h0, 16'h0, 16'hFFFF};
    @(negedge clk);
    seg_valid = 1'b0;
    model_seg(12, pa);
    model_seg(12, pb);
    wait_idle();
    @(negedge clk);
    wait_idle();
    flush_cmp("R9 buffered", 1, s);
    chk(s == 2, "R9 third strobe ignored", s, 2);
  endtask

  task automatic t_flush_busy();
    logic [15:0] p [K];
    int s;
    send_seg(4, 16'h3000, 16'h7000, 16'h2000);
    p[0] = 16'h6000; p[1] = 16'h2000; p[2] = 16'h1000;
    @(negedge clk);
    seg_valid = 1'b1; seg_dur = 8'd4; seg_prob = {p[2], p[1], p[0]};
    @(negedge clk);
    seg_valid = 1'b0; flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    model_seg(4, p);
    flush_cmp("R11 flush while busy", 0, s);
  endtask

  task automatic t_overflow();
    int s;
    chk(ovf === 1'b0, "R10 no overflow yet", int'(ovf), 0);
    send_seg(1, 16'hF000, 16'h2000, 16'h2000);
    send_seg(1, 16'hF000, 16'h2000, 16'h2000);
    send_seg(1, 16'h2000, 16'hF000, 16'h2000);
    send_seg(1, 16'hF000, 16'h2000, 16'h2000);
    send_seg(1, 16'hF000, 16'h2000, 16'h2000);
    send_seg(1, 16'hF000, 16'h2000, 16'h2000);
    chk(ovf === 1'b1, "R10 overflow flag", int'(ovf), 1);
    flush_cmp("R10 after overflow", 1, s);
    chk(ovf === 1'b1, "R10 flag sticky", int'(ovf), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single();
    t_empty();
    t_chain();
    t_prune();
    t_tie();
    t_buffer();
    t_flush_busy();
    t_overflow();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule